// File: doc/BRIEF.md
# Debug-Port Memory Read Sequencer

This block sits above a single-transaction serial-wire debug engine and turns a simple "read N words at this address" command into the full series of debug-port and access-port register transactions. On every start it brings the target's debug logic up: it reads the identification register, clears sticky errors, requests debug and system power, reads status, reads the access-port identification through bank 0xF, returns to bank 0, and programs the memory access port for 32-bit auto-incrementing transfers. Then it writes the transfer address, pads the link with idle cycles, and streams data-register reads.

Access-port reads are posted. Each returned value belongs to the read before it, so the first data read is thrown away and N words take N+1 reads. A WAIT answer repeats the same transaction up to a limit. A FAULT answer causes one ABORT write to clear the sticky error and ends the command. Any other answer ends the command at once.

The lower layer is driven with a level request and a one-cycle response strobe. Bit framing, parity and turnaround belong to that layer.

Top module: `swd_memrd_seq`

## Requirements
- R1: After a start, the transactions are issued in this order, where txn_ap=1 selects the access port, txn_rnw=1 means read, and txn_a is register offset bits [3:2]:
  1. DP read a=0.
  2. DP write a=0 of 0x0000001E.
  3. DP write a=1 of 0x50000000.
  4. DP read a=1.
  5. DP write a=2 of {AP_NUM,16'h0,8'hF0}.
  6. Two AP reads a=3.
  7. DP write a=2 of {AP_NUM,24'h0}.
  8. AP write a=0 of CSW_WORD (default 0x22000012).
  9. AP write a=1 of the command address.
- R2: After the address write is answered OK, link_idle is high for exactly IDLE_CYC cycles. No request is raised while link_idle is high.
- R3: A command with cmd_len=L delivers L+1 words through L+2 AP reads at a=3. The data of the first of those reads is discarded and never appears on word_data.
- R4: The k-th delivered word (k from 0) carries word_addr = start address + 4k. The transfer address is written only once per command.
- R5: A WAIT ack (3'b010) repeats the same transaction unchanged. The command continues normally once an OK ack (3'b001) arrives.
- R6: MAX_WAIT consecutive WAIT acks on one transaction end the command with cmd_status=2 (timeout). No further request follows.
- R7: A FAULT ack (3'b100) is followed by exactly one DP write a=0 of 0x0000001E. The command then ends with cmd_status=1 (fault), whatever ack that write receives.
- R8: Any other ack value ends the command with cmd_status=3 (protocol error). No further request follows.
- R9: txn_req stays high with a stable descriptor until txn_rsp_valid. It is low in the cycle after every response.
- R10: cmd_start while cmd_busy is high is ignored. The running command's transactions, words and status are unchanged.
- R11: After reset, cmd_busy, cmd_done, txn_req, word_valid and link_idle are low.
- R12: cmd_done is a one-cycle pulse. A successful command reports cmd_status=0 in the same cycle as its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse, accepted only when idle |
| cmd_addr | input | 32 | Address of the first word |
| cmd_len | input | LEN_W | Number of words minus one |
| cmd_busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| cmd_status | output | 2 | 0 ok, 1 fault, 2 timeout, 3 protocol error |
| word_valid | output | 1 | One-cycle strobe for a delivered word |
| word_data | output | 32 | Delivered word |
| word_addr | output | 32 | Target address of the delivered word |
| txn_req | output | 1 | Transaction request to the lower layer |
| txn_ap | output | 1 | 1 access port, 0 debug port |
| txn_rnw | output | 1 | 1 read, 0 write |
| txn_a | output | 2 | Register offset bits [3:2] |
| txn_wdata | output | 32 | Write data |
| txn_rsp_valid | input | 1 | Response strobe from the lower layer |
| txn_ack | input | 3 | Ack code of the response |
| txn_rdata | input | 32 | Read data of the response |
| link_idle | output | 1 | Lower layer must clock idle cycles |

## Verification
The assertions check the local rules on every cycle:
- the request handshake and descriptor stability;
- the rule against requests during idle padding;
- the pulse shape of done;
- the fact that a non-standard ack always ends the command.

The full ordering of register transactions, the discarding of the stale posted read, word addressing, the idle count, retries, timeout, the fault-clearing write and the ignored restart can only be shown by the bench. Its target model returns posted data and injects WAIT, FAULT and illegal acks at chosen transactions.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

   typedef struct packed {
      logic        ap;
      logic        rnw;
      logic [1:0]  a;
      logic [31:0] wdata;
   } swd_txn_t;

   typedef enum logic [1:0] {
      STAT_OK      = 2'd0,
      STAT_FAULT   = 2'd1,
      STAT_TIMEOUT = 2'd2,
      STAT_PROTO   = 2'd3
   } seq_status_e;

   typedef enum logic [1:0] {
      ACK_GOOD,
      ACK_RETRY,
      ACK_ERR,
      ACK_BAD
   } ack_class_e;

   typedef enum logic [1:0] {
      F_IDLE,
      F_GAP,
      F_REQ,
      F_PAD
   } fsm_e;

   localparam logic [2:0]  ACK_CODE_OK    = 3'b001;
   localparam logic [2:0]  ACK_CODE_WAIT  = 3'b010;
   localparam logic [2:0]  ACK_CODE_FAULT = 3'b100;
   localparam logic [31:0] CLEAR_ERRORS   = 32'h0000_001E;
   localparam logic [31:0] POWER_REQUEST  = 32'h5000_0000;
   localparam logic [3:0]  STEP_TAR       = 4'd9;
   localparam logic [3:0]  STEP_DRW       = 4'd10;

   function automatic swd_txn_t mk_txn(logic ap, logic rnw, logic [1:0] a,
                                       logic [31:0] wdata);
      swd_txn_t t;
      t.ap    = ap;
      t.rnw   = rnw;
      t.a     = a;
      t.wdata = wdata;
      return t;
   endfunction

endpackage

// File: rtl/swd_step_rom.sv
module swd_step_rom
   import swd_seq_pkg::*;
#(
   parameter logic [7:0]  AP_NUM   = 8'h00,
   parameter logic [31:0] CSW_WORD = 32'h2200_0012
) (
   input  logic [3:0]  step,
   input  logic [31:0] tar_addr,
   output swd_txn_t    txn_o
);

   localparam logic [31:0] SEL_IDENT = {AP_NUM, 16'h0000, 4'hF, 4'h0};
   localparam logic [31:0] SEL_MEM   = {AP_NUM, 24'h00_0000};

   always_comb begin
      case (step)
         4'd0:    txn_o = mk_txn(1'b0, 1'b1, 2'd0, 32'h0);
         4'd1:    txn_o = mk_txn(1'b0, 1'b0, 2'd0, CLEAR_ERRORS);
         4'd2:    txn_o = mk_txn(1'b0, 1'b0, 2'd1, POWER_REQUEST);
         4'd3:    txn_o = mk_txn(1'b0, 1'b1, 2'd1, 32'h0);
         4'd4:    txn_o = mk_txn(1'b0, 1'b0, 2'd2, SEL_IDENT);
         4'd5:    txn_o = mk_txn(1'b1, 1'b1, 2'd3, 32'h0);
         4'd6:    txn_o = mk_txn(1'b1, 1'b1, 2'd3, 32'h0);
         4'd7:    txn_o = mk_txn(1'b0, 1'b0, 2'd2, SEL_MEM);
         4'd8:    txn_o = mk_txn(1'b1, 1'b0, 2'd0, CSW_WORD);
         4'd9:    txn_o = mk_txn(1'b1, 1'b0, 2'd1, tar_addr);
         default: txn_o = mk_txn(1'b1, 1'b1, 2'd3, 32'h0);
      endcase
   end

endmodule

// File: rtl/swd_ack_eval.sv
module swd_ack_eval
   import swd_seq_pkg::*;
#(
   parameter int MAX_WAIT = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] ack_code,
   input  logic       eval_en,
   input  logic       clr,
   output ack_class_e cls_o,
   output logic       exhausted_o
);

   if (MAX_WAIT < 1) begin : g_bad_limit
      $error("swd_ack_eval: MAX_WAIT must be at least 1");
   end

   always_comb begin
      case (ack_code)
         ACK_CODE_OK:    cls_o = ACK_GOOD;
         ACK_CODE_WAIT:  cls_o = ACK_RETRY;
         ACK_CODE_FAULT: cls_o = ACK_ERR;
         default:        cls_o = ACK_BAD;
      endcase
   end

   if (MAX_WAIT == 1) begin : g_single
      assign exhausted_o = (cls_o == ACK_RETRY);
   end else begin : g_count
      localparam int CW = $clog2(MAX_WAIT);
      logic [CW-1:0] wcnt;

      assign exhausted_o = (cls_o == ACK_RETRY) && (wcnt == CW'(MAX_WAIT - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wcnt <= '0;
         end else if (clr) begin
            wcnt <= '0;
         end else if (eval_en && cls_o == ACK_RETRY && !exhausted_o) begin
            wcnt <= wcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/swd_idle_pad.sv
module swd_idle_pad #(
   parameter int IDLE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic active_o,
   output logic expire_o
);

   if (IDLE_CYC < 1) begin : g_bad_idle
      $error("swd_idle_pad: IDLE_CYC must be at least 1");
   end

   localparam int CW = $clog2(IDLE_CYC + 1);

   logic [CW-1:0] cnt;
   logic          active;

   assign active_o = active;
   assign expire_o = active && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (load) begin
         cnt    <= CW'(IDLE_CYC - 1);
         active <= 1'b1;
      end else if (expire_o) begin
         active <= 1'b0;
      end else if (active) begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/swd_memrd_seq.sv
module swd_memrd_seq
   import swd_seq_pkg::*;
#(
   parameter int          LEN_W     = 4,
   parameter int          MAX_WAIT  = 8,
   parameter int          IDLE_CYC  = 16,
   parameter int          ADDR_STEP = 4,
   parameter logic [7:0]  AP_NUM    = 8'h00,
   parameter logic [31:0] CSW_WORD  = 32'h2200_0012
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [31:0]      cmd_addr,
   input  logic [LEN_W-1:0] cmd_len,
   output logic             cmd_busy,
   output logic             cmd_done,
   output logic [1:0]       cmd_status,
   output logic             word_valid,
   output logic [31:0]      word_data,
   output logic [31:0]      word_addr,
   output logic             txn_req,
   output logic             txn_ap,
   output logic             txn_rnw,
   output logic [1:0]       txn_a,
   output logic [31:0]      txn_wdata,
   input  logic             txn_rsp_valid,
   input  logic [2:0]       txn_ack,
   input  logic [31:0]      txn_rdata,
   output logic             link_idle
);

   if (LEN_W < 1) begin : g_bad_len
      $error("swd_memrd_seq: LEN_W must be at least 1");
   end

   localparam int RW = LEN_W + 1;

   fsm_e          fsm;
   logic [3:0]    step;
   logic          clr_mode;
   logic [31:0]   tar_q;
   logic [31:0]   next_waddr;
   logic [LEN_W-1:0] len_q;
   logic [RW-1:0] rd_cnt;
   logic          done_q;
   logic [1:0]    status_q;
   logic          wv_q;
   logic [31:0]   wdata_q;
   logic [31:0]   waddr_q;

   swd_txn_t      rom_txn;
   swd_txn_t      cur_txn;
   ack_class_e    cls;
   logic          exhausted;
   logic          rsp_fire;
   logic          start_acc;
   logic          pad_load;
   logic          pad_expire;
   logic          last_read;

   assign rsp_fire  = (fsm == F_REQ) && txn_rsp_valid;
   assign start_acc = (fsm == F_IDLE) && cmd_start;
   assign pad_load  = rsp_fire && !clr_mode && (cls == ACK_GOOD) && (step == STEP_TAR);
   assign last_read = (rd_cnt == ({1'b0, len_q} + 1'b1));

   swd_step_rom #(
      .AP_NUM   (AP_NUM),
      .CSW_WORD (CSW_WORD)
   ) i_rom (
      .step     (step),
      .tar_addr (tar_q),
      .txn_o    (rom_txn)
   );

   swd_ack_eval #(
      .MAX_WAIT (MAX_WAIT)
   ) i_ack (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_code    (txn_ack),
      .eval_en     (rsp_fire && !clr_mode),
      .clr         (start_acc || (rsp_fire && cls == ACK_GOOD)),
      .cls_o       (cls),
      .exhausted_o (exhausted)
   );

   swd_idle_pad #(
      .IDLE_CYC (IDLE_CYC)
   ) i_pad (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pad_load),
      .active_o (link_idle),
      .expire_o (pad_expire)
   );

   assign cur_txn   = clr_mode ? mk_txn(1'b0, 1'b0, 2'd0, CLEAR_ERRORS) : rom_txn;
   assign txn_req   = (fsm == F_REQ);
   assign txn_ap    = cur_txn.ap;
   assign txn_rnw   = cur_txn.rnw;
   assign txn_a     = cur_txn.a;
   assign txn_wdata = cur_txn.wdata;

   assign cmd_busy   = (fsm != F_IDLE);
   assign cmd_done   = done_q;
   assign cmd_status = status_q;
   assign word_valid = wv_q;
   assign word_data  = wdata_q;
   assign word_addr  = waddr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm        <= F_IDLE;
         step       <= '0;
         clr_mode   <= 1'b0;
         tar_q      <= '0;
         next_waddr <= '0;
         len_q      <= '0;
         rd_cnt     <= '0;
         done_q     <= 1'b0;
         status_q   <= STAT_OK;
         wv_q       <= 1'b0;
         wdata_q    <= '0;
         waddr_q    <= '0;
      end else begin
         done_q <= 1'b0;
         wv_q   <= 1'b0;
         case (fsm)
            F_IDLE: begin
               if (cmd_start) begin
                  tar_q      <= cmd_addr;
                  next_waddr <= cmd_addr;
                  len_q      <= cmd_len;
                  step       <= '0;
                  rd_cnt     <= '0;
                  clr_mode   <= 1'b0;
                  fsm        <= F_GAP;
               end
            end
            F_GAP: begin
               fsm <= F_REQ;
            end
            F_REQ: begin
               if (txn_rsp_valid) begin
                  if (clr_mode) begin
                     fsm      <= F_IDLE;
                     done_q   <= 1'b1;
                     status_q <= STAT_FAULT;
                  end else begin
                     case (cls)
                        ACK_GOOD: begin
                           if (step == STEP_DRW) begin
                              if (rd_cnt != '0) begin
                                 wv_q       <= 1'b1;
                                 wdata_q    <= txn_rdata;
                                 waddr_q    <= next_waddr;
                                 next_waddr <= next_waddr + 32'(ADDR_STEP);
                              end
                              if (last_read) begin
                                 fsm      <= F_IDLE;
                                 done_q   <= 1'b1;
                                 status_q <= STAT_OK;
                              end else begin
                                 rd_cnt <= rd_cnt + 1'b1;
                                 fsm    <= F_GAP;
                              end
                           end else if (step == STEP_TAR) begin
                              fsm <= F_PAD;
                           end else begin
                              step <= step + 1'b1;
                              fsm  <= F_GAP;
                           end
                        end
                        ACK_RETRY: begin
                           if (exhausted) begin
                              fsm      <= F_IDLE;
                              done_q   <= 1'b1;
                              status_q <= STAT_TIMEOUT;
                           end else begin
                              fsm <= F_GAP;
                           end
                        end
                        ACK_ERR: begin
                           clr_mode <= 1'b1;
                           fsm      <= F_GAP;
                        end
                        default: begin
                           fsm      <= F_IDLE;
                           done_q   <= 1'b1;
                           status_q <= STAT_PROTO;
                        end
                     endcase
                  end
               end
            end
            F_PAD: begin
               if (pad_expire) begin
                  step <= STEP_DRW;
                  fsm  <= F_GAP;
               end
            end
            default: fsm <= F_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/swd_memrd_seq_chk.sv
module swd_memrd_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_start,
   input logic        cmd_busy,
   input logic        cmd_done,
   input logic        word_valid,
   input logic        txn_req,
   input logic        txn_ap,
   input logic        txn_rnw,
   input logic [1:0]  txn_a,
   input logic [31:0] txn_wdata,
   input logic        txn_rsp_valid,
   input logic [2:0]  txn_ack,
   input logic        link_idle
);

   a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      txn_req && !txn_rsp_valid |=> txn_req);

   a_r9_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      txn_req && txn_rsp_valid |=> !txn_req);

   a_r9_desc_stable: assert property (@(posedge clk) disable iff (!rst_n)
      txn_req && !txn_rsp_valid |=> $stable({txn_ap, txn_rnw, txn_a, txn_wdata}));

   a_r2_no_req_in_pad: assert property (@(posedge clk) disable iff (!rst_n)
      link_idle |-> !txn_req);

   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

   a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_busy |=> cmd_busy || cmd_done);

   a_r10_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_busy && cmd_start |=> cmd_busy);

   a_r8_bad_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
      txn_req && txn_rsp_valid && txn_ack != 3'b001 && txn_ack != 3'b010
      && txn_ack != 3'b100 |=> cmd_done);

   a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> !txn_req && !link_idle && !cmd_busy);

   a_r3_word_in_command: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(cmd_busy));

endmodule

bind swd_memrd_seq swd_memrd_seq_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_start     (cmd_start),
   .cmd_busy      (cmd_busy),
   .cmd_done      (cmd_done),
   .word_valid    (word_valid),
   .txn_req       (txn_req),
   .txn_ap        (txn_ap),
   .txn_rnw       (txn_rnw),
   .txn_a         (txn_a),
   .txn_wdata     (txn_wdata),
   .txn_rsp_valid (txn_rsp_valid),
   .txn_ack       (txn_ack),
   .link_idle     (link_idle)
);

// File: tb/test_swd_memrd_seq.sv
`timescale 1ns/1ps
module test_swd_memrd_seq;

   localparam int LEN_W = 4;
   localparam int MAXW  = 4;
   localparam int IDLE  = 16;
   localparam int LAT   = 2;
   localparam logic [31:0] IDENT = 32'h1477_0011;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_start = 1'b0;
   logic [31:0]      cmd_addr = '0;
   logic [LEN_W-1:0] cmd_len = '0;
   logic             cmd_busy, cmd_done, word_valid, link_idle;
   logic [1:0]       cmd_status;
   logic [31:0]      word_data, word_addr;
   logic             txn_req, txn_ap, txn_rnw;
   logic [1:0]       txn_a;
   logic [31:0]      txn_wdata;
   logic             txn_rsp_valid = 1'b0;
   logic [2:0]       txn_ack = 3'b000;
   logic [31:0]      txn_rdata = '0;

   always #2 clk = ~clk;

   swd_memrd_seq #(.LEN_W(LEN_W), .MAX_WAIT(MAXW), .IDLE_CYC(IDLE)) i_swd_memrd_seq (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
      .cmd_status(cmd_status), .word_valid(word_valid), .word_data(word_data),
      .word_addr(word_addr), .txn_req(txn_req), .txn_ap(txn_ap), .txn_rnw(txn_rnw),
      .txn_a(txn_a), .txn_wdata(txn_wdata), .txn_rsp_valid(txn_rsp_valid),
      .txn_ack(txn_ack), .txn_rdata(txn_rdata), .link_idle(link_idle));

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   typedef struct {
      logic [3:0]  kind;   // {ap, rnw, a}
      logic [31:0] wd;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] exp_words[$];
   logic [31:0] exp_addrs[$];
   int          inj_at = -1, inj_n = 0, req_num = 0, idle_seen = 0;
   logic [2:0]  inj_code = 3'b001;
   bit          done_seen = 0;
   logic [1:0]  got_status = '0;

   logic [3:0]  tgt_bank = '0;
   logic [31:0] tgt_tar = '0, tgt_post = '0;

   function automatic logic [31:0] mem(input logic [31:0] a);
      return {a[7:0], a[31:8]} ^ 32'hC3A5_0F96;
   endfunction

   // Target and lower-layer model
   initial begin
      forever begin
         @(negedge clk);
         if (txn_req) begin
            logic [3:0]  k;
            logic [2:0]  ack;
            logic [31:0] rd;
            k = {txn_ap, txn_rnw, txn_a};
            if (exp_q.size() == 0) begin
               chk(0, "R1", "unexpected request", {28'h0, k}, 32'h0);
            end else begin
               chk(k == exp_q[0].kind, "R1", "transaction kind", {28'h0, k},
                   {28'h0, exp_q[0].kind});
               if (!txn_rnw)
                  chk(txn_wdata == exp_q[0].wd, "R1", "write data", txn_wdata, exp_q[0].wd);
            end
            repeat (LAT) @(negedge clk);
            ack = (req_num >= inj_at && req_num < inj_at + inj_n) ? inj_code : 3'b001;
            req_num++;
            rd = 32'h1BA0_1477;
            if (ack == 3'b001) begin
               if (!txn_rnw && !txn_ap && txn_a == 2'd2) tgt_bank = txn_wdata[7:4];
               if (!txn_rnw && txn_ap && txn_a == 2'd1 && tgt_bank == 4'h0) tgt_tar = txn_wdata;
               if (txn_rnw && txn_ap && txn_a == 2'd3) begin
                  rd = tgt_post;
                  if (tgt_bank == 4'hF) tgt_post = IDENT;
                  else begin
                     tgt_post = mem(tgt_tar);
                     tgt_tar  = tgt_tar + 32'd4;
                  end
               end
            end
            if (ack != 3'b010 && exp_q.size() != 0) void'(exp_q.pop_front());
            txn_rsp_valid = 1'b1;
            txn_ack       = ack;
            txn_rdata     = rd;
            @(negedge clk);
            txn_rsp_valid = 1'b0;
            txn_rdata     = '0;
         end
      end
   end

   // Output monitor
   initial begin
      forever begin
         @(negedge clk);
         if (link_idle) idle_seen++;
         if (word_valid) begin
            if (exp_words.size() == 0) begin
               chk(0, "R3", "unexpected word", word_data, 32'h0);
            end else begin
               chk(word_data == exp_words[0], "R3", "word data", word_data, exp_words[0]);
               chk(word_addr == exp_addrs[0], "R4", "word address", word_addr, exp_addrs[0]);
               void'(exp_words.pop_front());
               void'(exp_addrs.pop_front());
            end
         end
         if (cmd_done) begin
            done_seen  = 1;
            got_status = cmd_status;
            if (exp_words.size() != 0)
               chk(0, "R12", "done before last word", 32'(exp_words.size()), 32'h0);
         end
      end
   end

   // Expected transactions: full list truncated at index stop (or complete if -1)
   task automatic build(input logic [31:0] addr, input int len, input int stop,
                        input bit add_abort, input bit words);
      exp_t full[$];
      full.push_back('{4'b0100, 32'h0});
      full.push_back('{4'b0000, 32'h1E});
      full.push_back('{4'b0001, 32'h5000_0000});
      full.push_back('{4'b0101, 32'h0});
      full.push_back('{4'b0010, 32'h0000_00F0});
      full.push_back('{4'b1111, 32'h0});
      full.push_back('{4'b1111, 32'h0});
      full.push_back('{4'b0010, 32'h0});
      full.push_back('{4'b1000, 32'h2200_0012});
      full.push_back('{4'b1001, addr});
      for (int i = 0; i < len + 2; i++) full.push_back('{4'b1111, 32'h0});
      exp_q.delete();
      for (int i = 0; i < full.size(); i++)
         if (stop < 0 || i <= stop) exp_q.push_back(full[i]);
      if (add_abort) exp_q.push_back('{4'b0000, 32'h1E});
      exp_words.delete();
      exp_addrs.delete();
      if (words)
         for (int i = 0; i <= len; i++) begin
            exp_words.push_back(mem(addr + 32'(4 * i)));
            exp_addrs.push_back(addr + 32'(4 * i));
         end
   endtask

   task automatic run(input logic [31:0] addr, input int len, input logic [1:0] st,
                      input string tag, input int left, input int idle_exp, input bit poke);
      done_seen = 0;
      idle_seen = 0;
      req_num   = 0;
      @(negedge clk);
      cmd_addr  = addr;
      cmd_len   = LEN_W'(len);
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      chk(cmd_busy == 1'b1, "R10", "busy after start", {31'h0, cmd_busy}, 32'h1);
      if (poke) begin
         repeat (20) @(negedge clk);
         cmd_addr  = 32'hDEAD_0000;
         cmd_len   = LEN_W'(7);
         cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
         chk(cmd_busy == 1'b1, "R10", "busy kept on second start", {31'h0, cmd_busy}, 32'h1);
      end
      while (!done_seen) @(negedge clk);
      chk(got_status == st, tag, "status", {30'h0, got_status}, {30'h0, st});
      chk(exp_q.size() == left, tag, "transactions left", 32'(exp_q.size()), 32'(left));
      chk(exp_words.size() == 0, "R3", "words missing", 32'(exp_words.size()), 32'h0);
      chk(idle_seen == idle_exp, "R2", "idle cycles", 32'(idle_seen), 32'(idle_exp));
      repeat (3) @(negedge clk);
      chk(!txn_req && !cmd_busy && !cmd_done, tag, "quiet after done",
          {29'h0, txn_req, cmd_busy, cmd_done}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R11 reset state
      chk({cmd_busy, cmd_done, txn_req, word_valid, link_idle} == 5'b0, "R11",
          "outputs in reset", {27'h0, cmd_busy, cmd_done, txn_req, word_valid, link_idle}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({cmd_busy, cmd_done, txn_req, word_valid, link_idle} == 5'b0, "R11",
          "outputs after reset", {27'h0, cmd_busy, cmd_done, txn_req, word_valid, link_idle}, 32'h0);

      // R1 R3 R12: single word
      build(32'h2000_0100, 0, -1, 0, 1);
      run(32'h2000_0100, 0, 2'd0, "R12", 0, IDLE, 0);

      // R4 multi-word with auto increment
      build(32'h4001_0C00, 3, -1, 0, 1);
      run(32'h4001_0C00, 3, 2'd0, "R4", 0, IDLE, 0);

      // R5 two WAITs on a data read then OK
      build(32'h0800_0040, 2, -1, 0, 1);
      inj_at = 12; inj_n = 2; inj_code = 3'b010;
      run(32'h0800_0040, 2, 2'd0, "R5", 0, IDLE, 0);

      // R6 WAIT limit reached on status read
      build(32'h0, 0, 3, 0, 0);
      inj_at = 3; inj_n = MAXW; inj_code = 3'b010;
      run(32'h0, 0, 2'd2, "R6", 1, 0, 0);

      // R7 FAULT on identification read, then clearing write
      build(32'h0, 0, 5, 1, 0);
      inj_at = 5; inj_n = 1; inj_code = 3'b100;
      run(32'h0, 0, 2'd1, "R7", 0, 0, 0);

      // R8 illegal ack on first data read
      build(32'h1000_0000, 1, 10, 0, 0);
      inj_at = 10; inj_n = 1; inj_code = 3'b111;
      run(32'h1000_0000, 1, 2'd3, "R8", 0, IDLE, 0);

      // R10 restart attempt while busy
      inj_at = -1; inj_n = 0;
      build(32'h2000_0800, 5, -1, 0, 1);
      run(32'h2000_0800, 5, 2'd0, "R10", 0, IDLE, 1);

      // R3 maximum length
      build(32'h2000_1000, 15, -1, 0, 1);
      run(32'h2000_1000, 15, 2'd0, "R3", 0, IDLE, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule